// File: doc/BRIEF.md
# Voice Enhancer Control Port over I2C

This block is the host-facing control slave of a voice-enhancement core. A host microcontroller sends it short I2C write transactions: a device address, a command byte and, for some commands, one data byte. These transactions select the processing mode (pass-through, enhancement or four-band equalizer), load equalizer presets, set single band gains, set the enhancement level and set a noise threshold. All of this is held in registers whose contents leave the block on plain output ports for the signal-processing datapath.

The host reads state back in two steps. A write with a status-select command chooses what the next read returns: either a packed status byte or the tone level of one band. A read transaction then returns that byte, MSB first, and the host ends it with a NACK.

SCL and SDA are sampled by the system clock. Each passes a three-sample majority filter before the bus conditions are decoded, so pulses one clock wide never reach the decoder. The block drives SDA only by pulling it low, through a single output that the pad turns into an open-drain driver.

Top module: `voice_ctl_i2c`

## Requirements
- R1: After reset the outputs are: `dsp_bypass`=1, `eq_mode`=0, `enh_level`=2'b01, every band gain code 12 (0 dB), `noise_thr`=0x1F, `sda_pull`=0.
- R2: The 7-bit slave address is binary 100000 followed by `addr_sel`. A matching address byte is ACKed by holding SDA low through the ninth SCL pulse. A non-matching address is not ACKed, and no later byte is ACKed or acted on until the next START.
- R3: Command 0x01 sets `dsp_bypass`=1 and leaves `eq_mode` as it is. Command 0x02 sets `dsp_bypass`=0 and `eq_mode`=0. Command 0x03 sets `dsp_bypass`=0 and `eq_mode`=1.
- R4: Commands 0x04 to 0x08 select equalizer mode (`dsp_bypass`=0, `eq_mode`=1) and load band gains in dB for bands 1/2/3/4: 0x04 0/0/0/0, 0x05 +3/-1/-1/+1, 0x06 +3/0/0/+3, 0x07 +5/0/0/0, 0x08 +5/0/0/+1.
- R5: Command 0x09 followed by data 0x00, 0x01 or 0x02 sets `enh_level` to that value (100%, 80%, 60%). Any other data value is ignored.
- R6: Command 0x0A followed by data D sets the gain code of band D[7:5]+1 to D[4:0]. Code 0 is +12 dB, code 12 is 0 dB and code 24 is -12 dB. Band 1 sits at `band_gain[4:0]` and band 4 at `band_gain[19:15]`. A data byte with D[7:5]>3 or D[4:0]>24 is ignored.
- R7: Command 0x0D followed by a data byte loads that byte into `noise_thr`.
- R8: Command 0x0E with data 0x01 makes reads return the status byte {4'b0000, `enh_level`, `eq_mode`, `dsp_bypass`}. This selection is also the reset default. Data outside 0x01..0x05 leaves the selection unchanged.
- R9: Command 0x0E with data 0x02 to 0x05 makes reads return the tone level of band 1 to 4 as 24 minus its gain code (0x00 is -12 dB, 0x18 is +12 dB).
- R10: Every byte of a write addressed to this slave is ACKed, including undefined command codes and extra bytes. Undefined commands change no output and no read-back value.
- R11: A low or high pulse one system clock wide on SDA while SCL is high creates neither a START nor a STOP, and does not corrupt the byte being received.
- R12: Register outputs hold their new values no later than 100 system clocks after the STOP of the write that set them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_sel | input | 1 | Least significant bit of the slave address |
| scl_in | input | 1 | SCL level from the pad |
| sda_in | input | 1 | SDA level from the pad |
| sda_pull | output | 1 | 1 = drive SDA low; 0 = release |
| dsp_bypass | output | 1 | 1 = processing off, audio passed straight through |
| eq_mode | output | 1 | 0 = enhancement mode, 1 = equalizer mode |
| enh_level | output | 2 | Enhancement level: 0 = 100%, 1 = 80%, 2 = 60% |
| band_gain | output | 20 | Four 5-bit gain codes, band 1 in the low bits |
| noise_thr | output | 8 | Noise threshold for the datapath |

## Verification
Bit sampling and START/STOP detection both look at the same SCL-high window, so a single-clock disturbance on SDA while SCL is high is seen by both at once. The bench drives a noise-threshold write in which every bit carries a pulse one clock wide in the direction that would fake a START (SDA high) or a STOP (SDA low). The write passes only if every byte is still ACKed and `noise_thr` ends up equal to the byte that was sent. A second case sets a status selection with one write and makes the following read depend on it, so a decode error in either step shows up as a wrong read-back byte.

// File: rtl/voice_ctl_i2c.sv
module voice_ctl_i2c #(
  parameter logic [5:0] ADDR_HI   = 6'b100000,
  parameter logic [7:0] NOISE_DEF = 8'h1F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        addr_sel,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        sda_pull,
  output logic        dsp_bypass,
  output logic        eq_mode,
  output logic [1:0]  enh_level,
  output logic [19:0] band_gain,
  output logic [7:0]  noise_thr
);

  localparam logic [4:0] ZERO_DB = 5'd12;
  localparam logic [4:0] MAX_CODE = 5'd24;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WR, S_RD, S_SKIP} st_t;

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[1] & v[2]) | (v[0] & v[2]);
  endfunction

  function automatic logic [19:0] preset(input logic [2:0] idx);
    case (idx)
      3'd1:    return {5'd11, 5'd13, 5'd13, 5'd9};
      3'd2:    return {5'd9,  5'd12, 5'd12, 5'd9};
      3'd3:    return {5'd12, 5'd12, 5'd12, 5'd7};
      3'd4:    return {5'd11, 5'd12, 5'd12, 5'd7};
      default: return {4{ZERO_DB}};
    endcase
  endfunction

  logic [2:0] scl_sh, sda_sh;
  logic       scl_f, sda_f, scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sh <= 3'b111; sda_sh <= 3'b111;
      scl_f  <= 1'b1;   sda_f  <= 1'b1;
      scl_p  <= 1'b1;   sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_in};
      sda_sh <= {sda_sh[1:0], sda_in};
      scl_f  <= maj3(scl_sh);
      sda_f  <= maj3(sda_sh);
      scl_p  <= scl_f;
      sda_p  <= sda_f;
    end
  end

  wire scl_rise  = scl_f & ~scl_p;
  wire scl_fall  = ~scl_f & scl_p;
  wire start_det = scl_f & scl_p & sda_p & ~sda_f;
  wire stop_det  = scl_f & scl_p & ~sda_p & sda_f;

  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sh, cmd_q, tx;
  logic [1:0] bidx;
  logic [2:0] rsel;
  logic [3:0][4:0] gains;
  logic [7:0] rd_byte;

  wire addr_hit = (sh[7:1] == {ADDR_HI, addr_sel});
  wire edge_ok  = ~start_det & ~stop_det;
  wire exec_wr  = edge_ok & scl_fall & (st == S_WR) & (cnt == 4'd8);

  always_comb begin
    rd_byte = {4'b0000, enh_level, eq_mode, dsp_bypass};
    if (rsel >= 3'd2 && rsel <= 3'd5)
      rd_byte = 8'd24 - {3'b000, gains[2'(rsel - 3'd2)]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; tx <= '0; bidx <= '0; sda_pull <= 1'b0;
    end else if (start_det) begin
      st <= S_ADDR; cnt <= '0; bidx <= '0; sda_pull <= 1'b0;
    end else if (stop_det) begin
      st <= S_IDLE; sda_pull <= 1'b0;
    end else if (scl_rise) begin
      if (st == S_ADDR || st == S_WR) begin
        if (cnt < 4'd8) sh <= {sh[6:0], sda_f};
        if (cnt < 4'd9) cnt <= cnt + 4'd1;
      end else if (st == S_RD && cnt < 4'd9) begin
        cnt <= cnt + 4'd1;
      end
    end else if (scl_fall) begin
      case (st)
        S_ADDR: begin
          if (cnt == 4'd8) begin
            if (addr_hit) sda_pull <= 1'b1;
            else          st <= S_SKIP;
          end else if (cnt == 4'd9) begin
            cnt <= '0;
            if (sh[0]) begin
              st <= S_RD; tx <= rd_byte; sda_pull <= ~rd_byte[7];
            end else begin
              st <= S_WR; bidx <= 2'd1; sda_pull <= 1'b0;
            end
          end
        end
        S_WR: begin
          if (cnt == 4'd8) sda_pull <= 1'b1;
          else if (cnt == 4'd9) begin
            sda_pull <= 1'b0; cnt <= '0;
            if (bidx != 2'd3) bidx <= bidx + 2'd1;
          end
        end
        S_RD: begin
          if (cnt >= 4'd1 && cnt <= 4'd7) sda_pull <= ~tx[3'(4'd7 - cnt)];
          else if (cnt == 4'd8)           sda_pull <= 1'b0;
          else if (cnt == 4'd9)           st <= S_SKIP;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dsp_bypass <= 1'b1; eq_mode <= 1'b0; enh_level <= 2'b01;
      gains <= {4{ZERO_DB}}; noise_thr <= NOISE_DEF; rsel <= 3'd1; cmd_q <= '0;
    end else if (exec_wr) begin
      if (bidx == 2'd1) begin
        cmd_q <= sh;
        case (sh)
          8'h01: dsp_bypass <= 1'b1;
          8'h02: begin dsp_bypass <= 1'b0; eq_mode <= 1'b0; end
          8'h03: begin dsp_bypass <= 1'b0; eq_mode <= 1'b1; end
          8'h04, 8'h05, 8'h06, 8'h07, 8'h08: begin
            dsp_bypass <= 1'b0; eq_mode <= 1'b1; gains <= preset(3'(sh - 8'h04));
          end
          default: ;
        endcase
      end else if (bidx == 2'd2) begin
        case (cmd_q)
          8'h09: if (sh <= 8'h02) enh_level <= sh[1:0];
          8'h0A: if (sh[7:5] <= 3'd3 && sh[4:0] <= MAX_CODE) gains[sh[6:5]] <= sh[4:0];
          8'h0D: noise_thr <= sh;
          8'h0E: if (sh >= 8'h01 && sh <= 8'h05) rsel <= sh[2:0];
          default: ;
        endcase
      end
    end
  end

  assign band_gain = gains;

  // R2
  pull_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE || st == S_SKIP) |-> !sda_pull);

  // R2
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == S_ADDR && !sda_pull && cnt == 4'd0));

  // R5
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enh_level != 2'b11);

  // R6
  gain_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    band_gain[4:0] <= MAX_CODE && band_gain[9:5] <= MAX_CODE &&
    band_gain[14:10] <= MAX_CODE && band_gain[19:15] <= MAX_CODE);

  // R10
  ack_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_wr |=> sda_pull);

  // R11
  filt_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |-> $past(scl_sh[1]) && $past(scl_sh[0]) || $past(scl_sh[2]));

endmodule

// File: tb/voice_ctl_i2c_bench.sv
module voice_ctl_i2c_bench;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_sel = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic glitch_lo = 1'b0, glitch_hi = 1'b0;
  logic sda_pull, dsp_bypass, eq_mode;
  logic [1:0] enh_level;
  logic [19:0] band_gain;
  logic [7:0] noise_thr;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  wire sda_line = sda_m & ~sda_pull;
  wire sda_pin  = (sda_line & ~glitch_lo) | glitch_hi;

  voice_ctl_i2c u_voice_ctl_i2c (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel),
    .scl_in(scl_m), .sda_in(sda_pin), .sda_pull(sda_pull),
    .dsp_bypass(dsp_bypass), .eq_mode(eq_mode), .enh_level(enh_level),
    .band_gain(band_gain), .noise_thr(noise_thr)
  );

  // {cmd, has_data, data, read select, expected read byte}
  localparam logic [27:0] VEC [14] = '{
    {8'h03, 1'b0, 8'h00, 3'd1, 8'h06},
    {8'h02, 1'b0, 8'h00, 3'd1, 8'h04},
    {8'h09, 1'b1, 8'h00, 3'd1, 8'h00},
    {8'h09, 1'b1, 8'h02, 3'd1, 8'h08},
    {8'h09, 1'b1, 8'h03, 3'd1, 8'h08},
    {8'h05, 1'b0, 8'h00, 3'd2, 8'h0F},
    {8'h0F, 1'b0, 8'h00, 3'd3, 8'h0B},
    {8'h08, 1'b0, 8'h00, 3'd5, 8'h0D},
    {8'h0A, 1'b1, 8'h20, 3'd3, 8'h18},
    {8'h0A, 1'b1, 8'h58, 3'd4, 8'h00},
    {8'h0A, 1'b1, 8'h19, 3'd2, 8'h11},
    {8'h0A, 1'b1, 8'h80, 3'd2, 8'h11},
    {8'h01, 1'b0, 8'h00, 3'd1, 8'h0B},
    {8'h04, 1'b0, 8'h00, 3'd4, 8'h0C}
  };
  localparam string TAGS [14] = '{"R3", "R3", "R5", "R5", "R5", "R4/R9", "R10",
                                  "R4/R9", "R6", "R6", "R6", "R6", "R3/R8", "R4/R9"};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic put_byte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(H);
      scl_m = 1'b1; tick(H/2);
      if (glitch) begin
        if (b[i]) glitch_lo = 1'b1; else glitch_hi = 1'b1;
      end
      tick(1);
      glitch_lo = 1'b0; glitch_hi = 1'b0;
      tick(H/2 - 1);
      scl_m = 1'b0; tick(2);
    end
    sda_m = 1'b1; tick(H - 2);
    scl_m = 1'b1; tick(H/2);
    ack = ~sda_line;
    tick(H/2);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic get_byte(output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H);
      scl_m = 1'b1; tick(H/2);
      b[i] = sda_line;
      tick(H/2);
      scl_m = 1'b0;
    end
    tick(H);
    scl_m = 1'b1; tick(H);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic wr_cmd(input logic [7:0] c, input bit has_d, input logic [7:0] d);
    bit ack;
    bus_start;
    put_byte({6'b100000, addr_sel, 1'b0}, 1'b0, ack); chk("R2 addr ack", ack, 1);
    put_byte(c, 1'b0, ack); chk("R10 cmd ack", ack, 1);
    if (has_d) begin
      put_byte(d, 1'b0, ack); chk("R10 data ack", ack, 1);
    end
    bus_stop;
    tick(100);
  endtask

  task automatic rd_now(output logic [7:0] b);
    bit ack;
    bus_start;
    put_byte({6'b100000, addr_sel, 1'b1}, 1'b0, ack); chk("R2 read addr ack", ack, 1);
    get_byte(b);
    bus_stop;
    tick(10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog actual=timeout expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rb;
    bit ack;
    tick(12);
    rst_n = 1'b1;
    tick(5);
    // R1 reset state
    chk("R1 bypass", dsp_bypass, 1);
    chk("R1 eq_mode", eq_mode, 0);
    chk("R1 level", enh_level, 2'b01);
    chk("R1 gains", band_gain, {4{5'd12}});
    chk("R1 noise", noise_thr, 8'h1F);
    chk("R1 sda_pull", sda_pull, 0);
    // R8 default read selection is status
    rd_now(rb); chk("R8 default status", rb, 8'h05);

    for (int i = 0; i < 14; i++) begin
      wr_cmd(VEC[i][27:20], VEC[i][19], VEC[i][18:11]);
      wr_cmd(8'h0E, 1'b1, {5'b0, VEC[i][10:8]});
      rd_now(rb);
      chk(TAGS[i], rb, VEC[i][7:0]);
    end
    // R4 flat preset at ports, R3 mode ports
    chk("R4 flat gains", band_gain, {4{5'd12}});
    chk("R3 bypass off", dsp_bypass, 0);
    chk("R3 eq on", eq_mode, 1);

    // R7 / R12 noise threshold visible within 100 clocks of STOP
    wr_cmd(8'h0D, 1'b1, 8'h40);
    chk("R7 R12 noise", noise_thr, 8'h40);

    // R11 glitches on every bit while SCL high
    bus_start;
    put_byte({6'b100000, addr_sel, 1'b0}, 1'b1, ack); chk("R11 addr ack", ack, 1);
    put_byte(8'h0D, 1'b1, ack); chk("R11 cmd ack", ack, 1);
    put_byte(8'h5A, 1'b1, ack); chk("R11 data ack", ack, 1);
    bus_stop; tick(100);
    chk("R11 noise", noise_thr, 8'h5A);

    // R2 wrong address: no ACK, bytes ignored
    bus_start;
    put_byte({6'b100000, ~addr_sel, 1'b0}, 1'b0, ack); chk("R2 nack addr", ack, 0);
    put_byte(8'h0D, 1'b0, ack); chk("R2 nack cmd", ack, 0);
    put_byte(8'h11, 1'b0, ack); chk("R2 nack data", ack, 0);
    bus_stop; tick(100);
    chk("R2 ignored", noise_thr, 8'h5A);

    // R10 extra byte after data is ACKed and ignored
    bus_start;
    put_byte({6'b100000, addr_sel, 1'b0}, 1'b0, ack);
    put_byte(8'h09, 1'b0, ack);
    put_byte(8'h01, 1'b0, ack);
    put_byte(8'h00, 1'b0, ack); chk("R10 extra ack", ack, 1);
    bus_stop; tick(100);
    chk("R10 extra ignored", enh_level, 2'b01);

    // R8 invalid selection keeps status selection
    wr_cmd(8'h0E, 1'b1, 8'h01);
    wr_cmd(8'h0E, 1'b1, 8'h09);
    rd_now(rb); chk("R8 invalid select", rb, 8'h06);

    // R2 other address pin value
    addr_sel = 1'b1;
    wr_cmd(8'h0D, 1'b1, 8'h33);
    chk("R2 addr_sel high", noise_thr, 8'h33);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule